// File: doc/BRIEF.md
# Dual-Sided Bridge Configuration Register Bank

This block holds the configuration state of a bridge that joins a local system bus to a PCI-style bus. It offers two independent register ports, one per bus side. Each port has an address, write data, a write strobe, a read strobe and registered read data. Behind the ports sit two register groups. The local group holds the bridge control bits and the PCI-to-local base register. The PCI group holds the command bits and a mirror word of one base bit.

Two pieces of storage are shared between the groups. The bus-master enable is a single flop, seen as control bit 1 from the local side and as command bit 2 from the PCI side. Bit 3 of the base register is a single flop, seen in the local base word and in the PCI word at offset E8h. This lets software on either side steer the bridge. Local writes into the PCI group go through only while the host-mode bit is set.

From the control and command bits the bank decodes a master enable, a target enable and a protection code. Neighbouring logic uses these to permit or block traffic in each direction. The bank has no states beyond its registers: the "mode" is a pure decode of the stored bits.

Top module: `bdg_cfg_regs`

## Requirements
- R1: The local port can write and read, at any time, the control word at local address 00h (bit 2 = host mode, bit 1 = master enable, other bits read 0) and the 32-bit base word at local address 04h.
- R2: Local address 40h is the local view of the PCI command word (bits [2:0]). A local write there takes effect only while host mode (control bit 2) is 1. In satellite mode it is dropped, and the word reads back unchanged.
- R3: Local control bit 1 and PCI command bit 2 are one storage bit. A write through either view changes it, and reads through local 00h bit 1, local 40h bit 2 and PCI 04h bit 2 all return the same value.
- R4: Base bit 3 is one storage bit. It is reachable as bit 3 of the local base word and as bit 3 of PCI offset E8h, which can be written from the PCI port at any time. All other bits at E8h read 0.
- R5: The master enable output is 1 when host mode or the shared master bit is 1, unless the protected code is decoded.
- R6: The protection code is 01b (run) when control bits [2:1] are 01b and command bits [1:0] are nonzero. In run mode both enables are 1.
- R7: The protection code is 10b (protected) when control bits [2:1] are 10b and command bits [1:0] are 00b. In protected mode both enables are 0.
- R8: Every other combination gives code 00b (other). In that case the target enable equals command bit 1 (memory enable) OR command bit 0 (I/O enable).
- R9: When both ports write the same storage bit in one cycle, the PCI-port value is kept.
- R10: Reset clears all storage and read data to 0. This gives satellite mode with code 00b and both enables 0. Reads of unimplemented offsets return 0.
- R11: Each port returns read data one clock after its read strobe, independently of the other port. The data shows the storage before any write in the same cycle. The read data is 0 in a cycle that follows no read strobe.
- R12: The PCI port can write the command word at PCI offset 04h (bits [2:0]) in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lb_addr | input | 8 | Local port byte address |
| lb_wdata | input | 32 | Local port write data |
| lb_we | input | 1 | Local port write strobe |
| lb_re | input | 1 | Local port read strobe |
| lb_rdata | output | 32 | Local port read data, one cycle after strobe |
| pc_addr | input | 8 | PCI port configuration byte offset |
| pc_wdata | input | 32 | PCI port write data |
| pc_we | input | 1 | PCI port write strobe |
| pc_re | input | 1 | PCI port read strobe |
| pc_rdata | output | 32 | PCI port read data, one cycle after strobe |
| mst_en | output | 1 | Local side may start PCI master cycles |
| tgt_en | output | 1 | PCI side may access the local bus |
| prot_code | output | 2 | 00 other, 01 run, 10 protected |

## Verification
The two functions that can meet in one cycle are a PCI-port write and a local-port write to the same shared bit: either the master bit, through local 00h or 40h against PCI 04h, or base bit 3, through local 04h against PCI E8h. The bench drives both strobes in one cycle with opposite values. A reference model that applies the PCI value last then judges the stored bit through reads and the master enable. A read on each port is also issued in the same cycle as a write, and the returned data must show the old value.

// File: rtl/bdg_cfg_pkg.sv
package bdg_cfg_pkg;
    localparam int AW = 8;
    localparam int DW = 32;

    localparam logic [AW-1:0] L_CTRL = 8'h00;
    localparam logic [AW-1:0] L_BASE = 8'h04;
    localparam logic [AW-1:0] L_PCMD = 8'h40;
    localparam logic [AW-1:0] P_CMD  = 8'h04;
    localparam logic [AW-1:0] P_BMIR = 8'hE8;

    localparam int SHARED_BASE_BIT = 3;

    typedef enum logic [1:0] {
        PM_OTHER = 2'b00,
        PM_RUN   = 2'b01,
        PM_PROT  = 2'b10
    } prot_e;

    typedef struct packed {
        logic       host;
        logic       mst;
        logic [1:0] cmd_lo;
    } mode_t;
endpackage

// File: rtl/bdg_cfg_store.sv
module bdg_cfg_store
    import bdg_cfg_pkg::*;
#(
    parameter int AWID = AW,
    parameter int DWID = DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AWID-1:0] lb_addr,
    input  logic [DWID-1:0] lb_wdata,
    input  logic            lb_we,
    input  logic [AWID-1:0] pc_addr,
    input  logic [DWID-1:0] pc_wdata,
    input  logic            pc_we,
    output mode_t           mode,
    output logic [DWID-1:0] base
);
    logic       host_q, mst_q;
    logic [1:0] cmd_q;
    logic [DWID-1:0] base_q;

    logic lb_ctrl_wr, lb_cmd_wr, lb_base_wr, pc_cmd_wr, pc_mir_wr;

    always_comb begin
        lb_ctrl_wr = lb_we && (lb_addr == L_CTRL);
        lb_cmd_wr  = lb_we && (lb_addr == L_PCMD) && host_q;
        lb_base_wr = lb_we && (lb_addr == L_BASE);
        pc_cmd_wr  = pc_we && (pc_addr == P_CMD);
        pc_mir_wr  = pc_we && (pc_addr == P_BMIR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_q <= 1'b0;
            mst_q  <= 1'b0;
            cmd_q  <= '0;
            base_q <= '0;
        end else begin
            if (lb_ctrl_wr)
                host_q <= lb_wdata[2];
            // PCI port has priority on every shared bit
            if (pc_cmd_wr)
                mst_q <= pc_wdata[2];
            else if (lb_cmd_wr)
                mst_q <= lb_wdata[2];
            else if (lb_ctrl_wr)
                mst_q <= lb_wdata[1];
            if (pc_cmd_wr)
                cmd_q <= pc_wdata[1:0];
            else if (lb_cmd_wr)
                cmd_q <= lb_wdata[1:0];
            if (lb_base_wr)
                base_q <= lb_wdata;
            if (pc_mir_wr)
                base_q[SHARED_BASE_BIT] <= pc_wdata[SHARED_BASE_BIT];
        end
    end

    assign mode = '{host: host_q, mst: mst_q, cmd_lo: cmd_q};
    assign base = base_q;

    // R2: satellite-mode local writes to the PCI view leave the command bits alone
    p_sat_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_we && lb_addr == L_PCMD && !host_q && !pc_we)
        |=> ($stable(cmd_q) && $stable(mst_q)));

    // R9: a PCI command write wins over a local control write in the same cycle
    p_pci_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_addr == P_CMD && lb_we && lb_addr == L_CTRL)
        |=> (mst_q == $past(pc_wdata[2])));

    // R4: PCI writes at E8h reach base bit 3
    p_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_addr == P_BMIR)
        |=> (base_q[SHARED_BASE_BIT] == $past(pc_wdata[SHARED_BASE_BIT])));
endmodule

// File: rtl/bdg_cfg_rdport.sv
module bdg_cfg_rdport
    import bdg_cfg_pkg::*;
#(
    parameter int AWID   = AW,
    parameter int DWID   = DW,
    parameter bit IS_PCI = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AWID-1:0] addr,
    input  logic            re,
    input  mode_t           mode,
    input  logic [DWID-1:0] base,
    output logic [DWID-1:0] rdata
);
    logic [DWID-1:0] rd_mux;

    generate
        if (IS_PCI) begin : g_pci_map
            always_comb begin
                rd_mux = '0;
                unique case (addr)
                    P_CMD:   rd_mux[2:0] = {mode.mst, mode.cmd_lo};
                    P_BMIR:  rd_mux[SHARED_BASE_BIT] = base[SHARED_BASE_BIT];
                    default: rd_mux = '0;
                endcase
            end
        end else begin : g_local_map
            always_comb begin
                rd_mux = '0;
                unique case (addr)
                    L_CTRL:  rd_mux[2:1] = {mode.host, mode.mst};
                    L_BASE:  rd_mux = base;
                    L_PCMD:  rd_mux[2:0] = {mode.mst, mode.cmd_lo};
                    default: rd_mux = '0;
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= re ? rd_mux : '0;
    end

    // R11: no strobe, no data
    p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> (rdata == '0));
endmodule

// File: rtl/bdg_cfg_prot.sv
module bdg_cfg_prot
    import bdg_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    output prot_e code,
    output logic  mst_en,
    output logic  tgt_en
);
    always_comb begin
        if ({mode.host, mode.mst} == 2'b01 && mode.cmd_lo != 2'b00)
            code = PM_RUN;
        else if ({mode.host, mode.mst} == 2'b10 && mode.cmd_lo == 2'b00)
            code = PM_PROT;
        else
            code = PM_OTHER;
    end

    always_comb begin
        mst_en = (mode.host | mode.mst) && (code != PM_PROT);
        tgt_en = (|mode.cmd_lo) && (code != PM_PROT);
    end

    // R7: protected mode blocks both directions
    p_prot_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (code == PM_PROT) |-> (!mst_en && !tgt_en));

    // R6: run mode opens both directions
    p_run_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code == PM_RUN) |-> (mst_en && tgt_en));
endmodule

// File: rtl/bdg_cfg_regs.sv
module bdg_cfg_regs
    import bdg_cfg_pkg::*;
#(
    parameter int AWID = AW,
    parameter int DWID = DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AWID-1:0] lb_addr,
    input  logic [DWID-1:0] lb_wdata,
    input  logic            lb_we,
    input  logic            lb_re,
    output logic [DWID-1:0] lb_rdata,
    input  logic [AWID-1:0] pc_addr,
    input  logic [DWID-1:0] pc_wdata,
    input  logic            pc_we,
    input  logic            pc_re,
    output logic [DWID-1:0] pc_rdata,
    output logic            mst_en,
    output logic            tgt_en,
    output logic [1:0]      prot_code
);
    mode_t           mode;
    logic [DWID-1:0] base;
    prot_e           code;

    bdg_cfg_store #(.AWID(AWID), .DWID(DWID)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_we(lb_we),
        .pc_addr(pc_addr), .pc_wdata(pc_wdata), .pc_we(pc_we),
        .mode(mode), .base(base)
    );

    bdg_cfg_rdport #(.AWID(AWID), .DWID(DWID), .IS_PCI(1'b0)) u_rd_local (
        .clk(clk), .rst_n(rst_n), .addr(lb_addr), .re(lb_re),
        .mode(mode), .base(base), .rdata(lb_rdata)
    );

    bdg_cfg_rdport #(.AWID(AWID), .DWID(DWID), .IS_PCI(1'b1)) u_rd_pci (
        .clk(clk), .rst_n(rst_n), .addr(pc_addr), .re(pc_re),
        .mode(mode), .base(base), .rdata(pc_rdata)
    );

    bdg_cfg_prot u_prot (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .code(code), .mst_en(mst_en), .tgt_en(tgt_en)
    );

    assign prot_code = code;

    // R3: both read views of the master bit agree one cycle after reads on both ports
    p_shared_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_re && lb_addr == L_PCMD && pc_re && pc_addr == P_CMD)
        |=> (lb_rdata[2:0] == pc_rdata[2:0]));
endmodule

// File: tb/bdg_cfg_regs_bench.sv
module bdg_cfg_regs_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  lb_addr = '0, pc_addr = '0;
    logic [31:0] lb_wdata = '0, pc_wdata = '0;
    logic        lb_we = 1'b0, lb_re = 1'b0, pc_we = 1'b0, pc_re = 1'b0;
    logic [31:0] lb_rdata, pc_rdata;
    logic        mst_en, tgt_en;
    logic [1:0]  prot_code;

    int n_run = 0, n_fail = 0;
    string cur_tag = "R10";
    bit done = 1'b0;

    // model state
    bit        m_host = 0, m_mst = 0;
    bit [1:0]  m_cmd = 0;
    bit [31:0] m_base = 0, m_lrd = 0, m_prd = 0;

    always #(CLK_P/2) clk = ~clk;

    bdg_cfg_regs u_bdg_cfg_regs (
        .clk(clk), .rst_n(rst_n),
        .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_we(lb_we), .lb_re(lb_re), .lb_rdata(lb_rdata),
        .pc_addr(pc_addr), .pc_wdata(pc_wdata), .pc_we(pc_we), .pc_re(pc_re), .pc_rdata(pc_rdata),
        .mst_en(mst_en), .tgt_en(tgt_en), .prot_code(prot_code)
    );

    function automatic bit [31:0] lmap(bit [7:0] a);
        case (a)
            8'h00:   return {29'd0, m_host, m_mst, 1'b0};
            8'h04:   return m_base;
            8'h40:   return {29'd0, m_mst, m_cmd};
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit [31:0] pmap(bit [7:0] a);
        case (a)
            8'h04:   return {29'd0, m_mst, m_cmd};
            8'hE8:   return {28'd0, m_base[3], 3'd0};
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit [1:0] exp_code();
        if (!m_host && m_mst && m_cmd != 0) return 2'b01;
        if (m_host && !m_mst && m_cmd == 0) return 2'b10;
        return 2'b00;
    endfunction

    // behavioural model, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_host = 0; m_mst = 0; m_cmd = 0; m_base = 0; m_lrd = 0; m_prd = 0;
        end else begin
            bit old_host;
            m_lrd = lb_re ? lmap(lb_addr) : 32'd0;
            m_prd = pc_re ? pmap(pc_addr) : 32'd0;
            old_host = m_host;
            // local writes first, PCI writes afterwards (R9: PCI value kept)
            if (lb_we && lb_addr == 8'h00) begin m_host = lb_wdata[2]; m_mst = lb_wdata[1]; end
            if (lb_we && lb_addr == 8'h04) m_base = lb_wdata;
            if (lb_we && lb_addr == 8'h40 && old_host) begin m_mst = lb_wdata[2]; m_cmd = lb_wdata[1:0]; end
            if (pc_we && pc_addr == 8'h04) begin m_mst = pc_wdata[2]; m_cmd = pc_wdata[1:0]; end
            if (pc_we && pc_addr == 8'hE8) m_base[3] = pc_wdata[3];
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare on every clock, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (!done) begin
            bit [1:0] ec;
            bit       emst, etgt;
            string    ptag;
            ec   = exp_code();
            emst = (m_host | m_mst) && ec != 2'b10;
            etgt = (m_cmd != 0) && ec != 2'b10;
            ptag = (ec == 2'b01) ? "R6" : (ec == 2'b10) ? "R7" : "R8";
            chk(cur_tag, "lb_rdata", lb_rdata, m_lrd);
            chk(cur_tag, "pc_rdata", pc_rdata, m_prd);
            chk("R5", "mst_en", {31'd0, mst_en}, {31'd0, emst});
            chk(ptag == "R8" ? "R8" : ptag, "tgt_en", {31'd0, tgt_en}, {31'd0, etgt});
            chk(ptag, "prot_code", {30'd0, prot_code}, {30'd0, ec});
        end
    end

    task automatic op(bit lwe, bit [7:0] la, bit [31:0] lwd, bit lre,
                      bit pwe, bit [7:0] pa, bit [31:0] pwd, bit pre);
        @(negedge clk);
        lb_we = lwe; lb_addr = la; lb_wdata = lwd; lb_re = lre;
        pc_we = pwe; pc_addr = pa; pc_wdata = pwd; pc_re = pre;
    endtask

    task automatic idle();
        op(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset values and unimplemented offsets
        cur_tag = "R10";
        op(0, 8'h00, 0, 1, 0, 8'h04, 0, 1);
        op(0, 8'h04, 0, 1, 0, 8'hE8, 0, 1);
        op(0, 8'h40, 0, 1, 0, 8'h20, 0, 1);
        op(0, 8'h10, 0, 1, 0, 8'h00, 0, 1);
        // R2: satellite mode drops local writes into the PCI view
        cur_tag = "R2";
        op(1, 8'h40, 32'h7, 0, 0, 0, 0, 0);
        op(0, 8'h40, 0, 1, 0, 8'h04, 0, 1);
        // R1: local group always writable
        cur_tag = "R1";
        op(1, 8'h04, 32'hA5A5_5A5F, 0, 0, 0, 0, 0);
        op(0, 8'h04, 0, 1, 0, 0, 0, 0);
        // R3: master bit set through the local control word, seen from PCI
        cur_tag = "R3";
        op(1, 8'h00, 32'h2, 0, 0, 0, 0, 0);
        op(0, 8'h40, 0, 1, 0, 8'h04, 0, 1);
        // R12: PCI command write clears master, sets access enables
        cur_tag = "R12";
        op(0, 0, 0, 0, 1, 8'h04, 32'h3, 0);
        op(0, 8'h00, 0, 1, 0, 8'h04, 0, 1);
        // R6: run mode
        cur_tag = "R6";
        op(1, 8'h00, 32'h2, 0, 0, 0, 0, 0);
        op(0, 8'h00, 0, 1, 0, 8'h04, 0, 1);
        // R7: protected mode
        cur_tag = "R7";
        op(1, 8'h00, 32'h4, 0, 1, 8'h04, 32'h0, 0);
        op(0, 8'h00, 0, 1, 0, 8'h04, 0, 1);
        // R2 in host mode: local write into PCI view is accepted
        cur_tag = "R2";
        op(1, 8'h40, 32'h5, 0, 0, 0, 0, 0);
        op(0, 8'h40, 0, 1, 0, 8'h04, 0, 1);
        // R8: other code with only I/O enable
        cur_tag = "R8";
        op(1, 8'h00, 32'h0, 0, 0, 0, 0, 0);
        op(0, 0, 0, 0, 1, 8'h04, 32'h1, 0);
        idle();
        // R4: base bit 3 via E8h
        cur_tag = "R4";
        op(0, 0, 0, 0, 1, 8'hE8, 32'h0, 0);
        op(0, 8'h04, 0, 1, 0, 8'hE8, 0, 1);
        op(0, 0, 0, 0, 1, 8'hE8, 32'hFFFF_FFFF, 0);
        op(0, 8'h04, 0, 1, 0, 8'hE8, 0, 1);
        // R9: same-cycle writes to shared bits
        cur_tag = "R9";
        op(1, 8'h00, 32'h6, 0, 1, 8'h04, 32'h0, 0);
        op(0, 8'h00, 0, 1, 0, 8'h04, 0, 1);
        op(1, 8'h04, 32'h0000_0008, 0, 1, 8'hE8, 32'h0, 0);
        op(0, 8'h04, 0, 1, 0, 8'hE8, 0, 1);
        op(1, 8'h40, 32'h4, 0, 1, 8'h04, 32'h2, 0);
        op(0, 8'h40, 0, 1, 0, 8'h04, 0, 1);
        // R11: reads alongside writes return old data; mixed traffic
        cur_tag = "R11";
        op(1, 8'h04, 32'h1234_5678, 1, 1, 8'h04, 32'h7, 1);
        op(0, 8'h04, 0, 1, 0, 8'h04, 0, 0);
        for (int i = 0; i < 400; i++) begin
            bit [7:0] la, pa;
            int sel;
            sel = $urandom_range(0, 4);
            la  = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h04 : (sel == 2) ? 8'h40 : (sel == 3) ? 8'h08 : 8'h44;
            sel = $urandom_range(0, 2);
            pa  = (sel == 0) ? 8'h04 : (sel == 1) ? 8'hE8 : 8'h10;
            op($urandom_range(0, 1), la, $urandom, $urandom_range(0, 1),
               $urandom_range(0, 1), pa, $urandom, $urandom_range(0, 1));
        end
        idle();
        idle();
        finish_run();
    end
endmodule